// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the counting core of a dual-modulus feedback divider in a frequency synthesizer loop. It runs on the output clock of an external dual-modulus prescaler. In each output period it holds the prescaler in its larger modulus (P+1) for the first A prescaler cycles and in its smaller modulus (P) for the rest of the N cycles in the period. Measured at the prescaler input, the division ratio is N·P + A. A one-cycle comparison pulse marks the end of each period.

The main count N, the swallow count A and the prescaler ratio selection come from a counter latch that is programmed elsewhere. The block reads them only at a period boundary, so rewriting the latch in the middle of a period never produces a malformed period. Values outside the usable range are clamped: N is raised to at least 3, and A is reduced to at most N. The selected ratio also goes out to the prescaler, and it too changes only at a boundary.

Top module: `pswallow_div`

## Requirements
- R1: While `rst_n` is low, `mod_ctl`, `fp` and `ratio_out` are all 0. The first rising `pclk` edge after release starts a new period.
- R2: Each output period spans exactly N·P + A input cycles of the prescaler. P is 32 when the sampled ratio select is 0 and 64 when it is 1.
- R3: `mod_ctl` is 1 during exactly the first A `pclk` cycles of a period and 0 during the remaining cycles of that period.
- R4: `fp` is 1 during exactly the last `pclk` cycle of each N-cycle period and 0 in every other cycle.
- R5: `main_count`, `swallow_count` and `ratio_sel` are sampled only at the first edge after reset and at the edge that ends a period. A change between those edges has no effect on the period in progress.
- R6: `ratio_out` carries the sampled ratio select (1 = divide by 64/65, 0 = divide by 32/33) and changes only at a period boundary.
- R7: A main count below 3 (0, 1 or 2) is treated as 3.
- R8: A swallow count greater than the effective main count is treated as equal to it. `mod_ctl` then stays 1 for the whole period.
- R9: A swallow count of 0 keeps `mod_ctl` at 0 for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_count | input | 11 | Main count N from the counter latch |
| swallow_count | input | 7 | Swallow count A from the counter latch |
| ratio_sel | input | 1 | Prescaler ratio select: 0 = 32/33, 1 = 64/65 |
| mod_ctl | output | 1 | Modulus control to the prescaler: 1 = divide by P+1 |
| ratio_out | output | 1 | Ratio select forwarded to the prescaler, updated at boundaries |
| fp | output | 1 | Divided comparison pulse, one `pclk` cycle wide |

## Verification
The hardest situation to reach is a counter-latch rewrite that lands in the middle of a period. The divided period must still match the old values exactly, and the new ratio must reach the prescaler only at the boundary. The bench builds a behavioural prescaler that feeds `mod_ctl` and `ratio_out` back into its own divide length. It changes all three inputs at arbitrary points inside a period and measures the input-clock cycles between comparison pulses against N·P + A for the values that were sampled. The bench also drives clamped counts, A = 0, A = N and A > N, so that the per-cycle model can confirm the modulus pattern at the edges of its range.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

   // Prescaler ratio as seen by the divider
   typedef enum logic {
      RATIO_32_33 = 1'b0,
      RATIO_64_65 = 1'b1
   } ratio_e;

   // Counter-latch snapshot taken at a period boundary
   typedef struct packed {
      logic [10:0] main_eff;
      logic [6:0]  swal_eff;
      ratio_e      ratio;
   } snap_t;

endpackage

// File: rtl/pswd_count_fix.sv
// Turns the raw latch values into the effective counts used for one period.
module pswd_count_fix #(
   parameter int MAIN_W        = 11,
   parameter int SWAL_W        = 7,
   parameter int MAIN_MIN      = 3,
   parameter bit CLAMP_SWALLOW = 1'b1
) (
   input  logic [MAIN_W-1:0] main_raw,
   input  logic [SWAL_W-1:0] swal_raw,
   output logic [MAIN_W-1:0] main_eff,
   output logic [SWAL_W-1:0] swal_eff
);
   localparam int CMP_W = (MAIN_W > SWAL_W) ? MAIN_W : SWAL_W;
   localparam logic [MAIN_W-1:0] MIN_V = MAIN_W'(MAIN_MIN);

   logic [CMP_W-1:0] main_ext;
   logic [CMP_W-1:0] swal_ext;

   always_comb begin
      main_eff = (main_raw < MIN_V) ? MIN_V : main_raw;
   end

   assign main_ext = CMP_W'(main_eff);
   assign swal_ext = CMP_W'(swal_raw);

   generate
      if (CLAMP_SWALLOW) begin : g_clamp
         always_comb begin
            if (swal_ext > main_ext) swal_eff = SWAL_W'(main_ext);
            else                     swal_eff = swal_raw;
         end
      end else begin : g_pass
         always_comb swal_eff = swal_raw;
      end
   endgenerate
endmodule

// File: rtl/pswd_main_cnt.sv
// Main counter: counts the pclk cycles left in the period and asks for a reload.
module pswd_main_cnt #(
   parameter int MAIN_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MAIN_W-1:0] load_val,
   output logic              reload,
   output logic              running,
   output logic              last
);
   logic [MAIN_W-1:0] rem_q;
   logic              run_q;

   assign running = run_q;
   assign last    = run_q && (rem_q == '0);
   assign reload  = !run_q || (rem_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         run_q <= 1'b0;
      end else begin
         run_q <= 1'b1;
         if (reload) rem_q <= load_val - MAIN_W'(1);
         else        rem_q <= rem_q - MAIN_W'(1);
      end
   end
endmodule

// File: rtl/pswd_swal_cnt.sv
// Swallow counter: holds the larger modulus until it has counted down to zero.
module pswd_swal_cnt #(
   parameter int SWAL_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic [SWAL_W-1:0] load_val,
   output logic              swallow
);
   logic [SWAL_W-1:0] rem_q;

   assign swallow = (rem_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rem_q <= '0;
      else if (reload)  rem_q <= load_val;
      else if (swallow) rem_q <= rem_q - SWAL_W'(1);
   end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
   parameter int MAIN_W        = 11,
   parameter int SWAL_W        = 7,
   parameter int MAIN_MIN      = 3,
   parameter bit CLAMP_SWALLOW = 1'b1
) (
   input  logic              pclk,
   input  logic              rst_n,
   input  logic [MAIN_W-1:0] main_count,
   input  logic [SWAL_W-1:0] swallow_count,
   input  logic              ratio_sel,
   output logic              mod_ctl,
   output logic              ratio_out,
   output logic              fp
);
   import pswd_pkg::*;

   localparam int MAIN_MAX = (1 << MAIN_W) - 1;

   generate
      if (MAIN_MIN < 2) begin : g_bad_min
         $error("pswallow_div: MAIN_MIN must be at least 2");
      end
      if (MAIN_MIN > MAIN_MAX) begin : g_bad_range
         $error("pswallow_div: MAIN_MIN does not fit in MAIN_W");
      end
      if (SWAL_W < 1 || MAIN_W < 2) begin : g_bad_width
         $error("pswallow_div: counter widths too small");
      end
   endgenerate

   logic [MAIN_W-1:0] main_eff;
   logic [SWAL_W-1:0] swal_eff;
   logic              reload;
   logic              running;
   logic              last;
   logic              swallow;
   ratio_e            ratio_q;

   pswd_count_fix #(
      .MAIN_W(MAIN_W), .SWAL_W(SWAL_W),
      .MAIN_MIN(MAIN_MIN), .CLAMP_SWALLOW(CLAMP_SWALLOW)
   ) u_fix (
      .main_raw(main_count),
      .swal_raw(swallow_count),
      .main_eff(main_eff),
      .swal_eff(swal_eff)
   );

   pswd_main_cnt #(.MAIN_W(MAIN_W)) u_main (
      .clk(pclk), .rst_n(rst_n), .load_val(main_eff),
      .reload(reload), .running(running), .last(last)
   );

   pswd_swal_cnt #(.SWAL_W(SWAL_W)) u_swal (
      .clk(pclk), .rst_n(rst_n), .reload(reload),
      .load_val(swal_eff), .swallow(swallow)
   );

   always_ff @(posedge pclk or negedge rst_n) begin
      if (!rst_n)      ratio_q <= RATIO_32_33;
      else if (reload) ratio_q <= ratio_e'(ratio_sel);
   end

   assign mod_ctl   = swallow;
   assign fp        = last;
   assign ratio_out = ratio_q;
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk (
   input logic clk,
   input logic rst_n,
   input logic running,
   input logic fp,
   input logic mod_ctl,
   input logic ratio_out
);
   logic [3:0] gap_q;
   logic       seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (fp) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (gap_q != 4'hF) begin
         gap_q  <= gap_q + 4'd1;
      end
   end

   // R4: the pulse is never two cycles wide
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fp |=> !fp);

   // R7: consecutive pulses are at least three cycles apart
   a_r7_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (fp && seen_q) |-> (gap_q >= 4'd2));

   // R3: once the modulus drops inside a period it stays low until the boundary
   a_r3_mod_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !mod_ctl && !fp) |=> !mod_ctl);

   // R6: the ratio only moves at a boundary
   a_r6_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !fp) |=> $stable(ratio_out));

   // R1: nothing is active before the first period starts
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!fp && !mod_ctl));
endmodule

bind pswallow_div pswallow_div_chk u_chk (
   .clk(pclk), .rst_n(rst_n), .running(running),
   .fp(fp), .mod_ctl(mod_ctl), .ratio_out(ratio_out)
);

// File: tb/tb_pswallow_div.sv
`timescale 1ns/1ps
module tb_pswallow_div;
   logic        vco = 1'b0;
   logic        pclk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] n_in = 11'd5;
   logic [6:0]  a_in = 7'd2;
   logic        s_in = 1'b0;
   logic        mod_ctl, ratio_out, fp;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 vco = ~vco;   // 200 MHz prescaler input

   pswallow_div dut (
      .pclk(pclk), .rst_n(rst_n), .main_count(n_in), .swallow_count(a_in),
      .ratio_sel(s_in), .mod_ctl(mod_ctl), .ratio_out(ratio_out), .fp(fp)
   );

   // Behavioural dual-modulus prescaler
   int      c = 0;
   int      div = 32;
   longint  vcount = 0;
   longint  last_end = 0;
   bit      meas = 0;
   int      exp_q[$];

   always @(posedge vco) begin
      vcount++;
      if (c == div - 1 && rst_n) begin
         if (!meas) begin
            meas = 1;
            last_end = vcount;
         end else if (fp) begin
            // R2: input cycles per output period
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R2: period ended with no expected length (actual %0d)", vcount - last_end);
            end else begin
               int e;
               e = exp_q.pop_front();
               if (vcount - last_end != longint'(e)) begin
                  errors++;
                  $display("FAIL R2: period length actual %0d expected %0d", vcount - last_end, e);
               end
            end
            last_end = vcount;
         end
      end
      if (c == div - 1) begin c <= 0; pclk <= 1'b1; end
      else              begin c <= c + 1; pclk <= 1'b0; end
      if (c == 1) div <= (ratio_out ? 64 : 32) + (mod_ctl ? 1 : 0);
   end

   // Reference model, one step per prescaler output cycle
   bit started = 0;
   int mN = 0, mA = 0, k = 0;
   bit msel = 0;
   bit e_mod = 0, e_fp = 0, e_sel = 0;

   always @(posedge pclk) begin
      if (rst_n) begin
         if (!started || k == mN - 1) begin
            // R5: latch values are taken only here; R7 and R8 clamps
            mN = (int'(n_in) < 3) ? 3 : int'(n_in);
            mA = (int'(a_in) > mN) ? mN : int'(a_in);
            msel = s_in;
            k = 0;
            started = 1;
            exp_q.push_back(mN * (msel ? 64 : 32) + mA);
         end else begin
            k++;
         end
         e_mod = (k < mA);
         e_fp  = (k == mN - 1);
         e_sel = msel;
      end
   end

   always @(negedge vco) begin
      if (pclk && !done) begin
         if (!rst_n) begin
            checks++;
            if (mod_ctl !== 1'b0 || fp !== 1'b0 || ratio_out !== 1'b0) begin
               errors++;
               $display("FAIL R1: in reset mod/fp/ratio actual %b%b%b expected 000",
                        mod_ctl, fp, ratio_out);
            end
         end else if (started) begin
            checks++;
            if (mod_ctl !== e_mod) begin
               errors++;
               $display("FAIL R3: mod_ctl at cycle %0d actual %b expected %b", k, mod_ctl, e_mod);
            end
            checks++;
            if (fp !== e_fp) begin
               errors++;
               $display("FAIL R4: fp at cycle %0d actual %b expected %b", k, fp, e_fp);
            end
            checks++;
            if (ratio_out !== e_sel) begin
               errors++;
               $display("FAIL R6: ratio_out actual %b expected %b", ratio_out, e_sel);
            end
         end
      end
   end

   task automatic set_in(input int n, input int a, input bit s);
      @(negedge vco);
      n_in = 11'(n);
      a_in = 7'(a);
      s_in = s;
   endtask

   task automatic run_periods(input int np);
      for (int i = 0; i < np; i++) begin
         @(negedge vco);
         while (!(pclk && fp)) @(negedge vco);
      end
   endtask

   task automatic wait_pclk(input int np);
      for (int i = 0; i < np; i++) @(posedge pclk);
   endtask

   task automatic finish_run;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200) @(posedge vco);   // R1 checked on each pclk in reset
      #1 rst_n = 1'b1;
      run_periods(3);
      set_in(8, 0, 0);      // R9: no swallow cycles
      run_periods(3);
      set_in(6, 6, 0);      // A equal to N
      run_periods(2);
      set_in(4, 9, 0);      // R8: A above N clamped
      run_periods(3);
      set_in(1, 1, 0);      // R7: N below minimum
      run_periods(2);
      set_in(0, 0, 1);      // R7 with the 64/65 ratio
      run_periods(3);
      set_in(10, 3, 1);     // R6: ratio 64/65
      run_periods(3);
      set_in(12, 5, 0);     // R5: rewrite mid-period, old values must hold
      run_periods(2);
      wait_pclk(4);
      set_in(7, 1, 1);
      wait_pclk(2);
      set_in(9, 8, 0);
      run_periods(3);
      set_in(130, 127, 0);  // widest swallow count
      run_periods(3);
      wait_pclk(3);
      finish_run();
   end

   initial begin
      repeat (180000) @(posedge vco);
      errors++;
      $display("FAIL watchdog (all requirements): run incomplete, actual timeout expected finish");
      finish_run();
   end
endmodule